// File: doc/BRIEF.md
# Firmware Record Stream Parser

This block walks a firmware image that arrives as a byte stream and turns it into the byte stream that feeds an SPI serializer. The image is a chain of variable-length records. Each record opens with an 8-byte header: a command byte, a 24-bit little-endian payload length and a 32-bit little-endian address. The payload follows the header, so a record spans its length plus 8 bytes. A job starts with a pulse on `start_i` that carries the total image size in bytes. The first record must be an information record. Its payload names the format version and the target device. The parser checks that record, swallows it, and then forwards every later record, header included.

On the way out, each record is cut into 8-byte groups and each group is sent in reverse byte order, so little-endian 64-bit words leave big-endian. A record whose size is not a multiple of 8 is zero-padded to fill its last group. The output marks the last byte of every record and the bytes of the final record. The final record is the one whose end offset reaches or passes the image size. A boot-failure input stops the job before any record that has not yet been queued for output.

Top module: `fw_record_parser`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `out_valid_o` and `in_ready_o` are low and `err_o` is 0.
- R2: After `start_i` in the idle state, the block takes input bytes. Bytes 0 to 7 of each record are the header: byte 0 is the command, bytes 1 to 3 are the length (LSB first) and bytes 4 to 7 are the address (LSB first). A record occupies length+8 input bytes.
- R3: If the first record's command is not 0xFF, the job ends with `err_o`=1 and nothing is emitted. Only the 8 header bytes are consumed.
- R4: In the first record, payload byte 0 is the version and must equal `INFO_VER` (default 1), else `err_o`=2. Payload byte 3 is the target and must equal `TARGET_ID` (default 10), else `err_o`=3. A length below 4 gives `err_o`=4 after the header alone.
- R5: The information record is consumed and never emitted. Every later record is emitted in full, header included.
- R6: Counting from the record's first byte, each group of 8 bytes is emitted in the order of positions 7, 6, …, 0.
- R7: If a record's length+8 is not a multiple of 8, its last group is filled with zero bytes at the missing high positions. Those zero bytes leave first within that group.
- R8: `out_last_o` is high exactly on the last emitted byte of each record.
- R9: `out_final_o` is high on every emitted byte of the record whose running end offset is at least the image size. That offset counts every record, the information record included. After that record, `done_o` pulses with `err_o`=0 and no further input byte is taken. This holds even when the information record itself reaches the size.
- R10: Once `boot_fail_i` has been seen high during a job, no record that has not yet been queued for output is emitted. A record already being emitted completes. The job ends with `err_o`=5.
- R11: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o`, `out_data_o`, `out_last_o` and `out_final_o` hold.
- R12: `busy_o` is high from the cycle after `start_i` until `done_o`. `done_o` is a single-cycle pulse, given only once all output has drained. `busy_o` is low the cycle after.
- R13: `start_i` and `image_bytes_i` are ignored while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a job when idle |
| image_bytes_i | input | SIZE_W | Total image size in bytes, sampled with start_i |
| boot_fail_i | input | 1 | Stops the job at the next record |
| in_valid_i | input | 1 | Input byte valid |
| in_data_i | input | 8 | Input byte |
| in_ready_o | output | 1 | Input byte accepted when high with in_valid_i |
| out_valid_o | output | 1 | Output byte valid |
| out_data_o | output | 8 | Output byte |
| out_last_o | output | 1 | Last byte of a record |
| out_final_o | output | 1 | Byte belongs to the final record |
| out_ready_i | input | 1 | Output byte taken when high with out_valid_o |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle end-of-job pulse |
| err_o | output | 3 | Job result: 0 ok, 1 no info, 2 version, 3 target, 4 short info, 5 aborted |

## Verification
The assertions assume that the input stream holds enough bytes to complete every record it announces. They also assume an image size of at least 8, so that the first header is always complete. Every bench image is built as whole records and sized to match. The assertions also take it that a downstream consumer may stall at any cycle. The bench therefore drops `out_ready_i` on a fixed pattern and gaps `in_valid_i` on another, which exercises the hold rule and overlap between header collection and group draining. The boot-failure input is raised either before the first header completes or at the first output byte, which is before the next record is queued.

// File: rtl/fwp_pkg.sv
package fwp_pkg;
  localparam int HDR_BYTES    = 8;
  localparam int GRP_BYTES    = 8;
  localparam int LEN_W        = 24;
  localparam int INFO_MIN_LEN = 4;
  localparam logic [7:0] CMD_INFO = 8'hFF;

  typedef enum logic [2:0] {
    ERR_NONE       = 3'd0,
    ERR_NOT_INFO   = 3'd1,
    ERR_VERSION    = 3'd2,
    ERR_TARGET     = 3'd3,
    ERR_SHORT_INFO = 3'd4,
    ERR_ABORT      = 3'd5
  } err_e;

  typedef enum logic [3:0] {
    S_IDLE, S_HDR, S_DECIDE, S_INFO, S_INFO_CHK, S_LOAD, S_BODY, S_FLUSH, S_END
  } state_e;
endpackage

// File: rtl/fwp_hdr_cap.sv
module fwp_hdr_cap #(
  parameter int NB = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            wr_i,
  input  logic [7:0]      data_i,
  output logic [8*NB-1:0] hdr_o,
  output logic            full_o
);
  localparam int CW = $clog2(NB + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (wr_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign full_o = (cnt_q == CW'(NB));

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [7:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         byte_q <= '0;
      else if (wr_i && cnt_q == CW'(g))    byte_q <= data_i;
    end
    assign hdr_o[8*g +: 8] = byte_q;
  end

  p_hdr_no_over_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> !full_o);
endmodule

// File: rtl/fwp_grp_swap.sv
module fwp_grp_swap #(
  parameter int NB = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [8*NB-1:0] load_data_i,
  input  logic            push_i,
  input  logic [7:0]      push_data_i,
  input  logic            rec_last_i,
  input  logic            rec_final_i,
  output logic            idle_o,
  output logic            can_push_o,
  output logic            out_valid_o,
  output logic [7:0]      out_data_o,
  output logic            out_last_o,
  output logic            out_final_o,
  input  logic            out_ready_i
);
  localparam int IW = $clog2(NB);
  localparam logic [IW-1:0] TOP = IW'(NB - 1);

  logic          drain_q;
  logic [IW-1:0] fcnt_q, didx_q;
  logic          tag_last_q, tag_final_q;
  logic [7:0]    lane_q [NB];
  logic          drain_done;

  assign drain_done = drain_q && out_ready_i && (didx_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drain_q     <= 1'b0;
      fcnt_q      <= '0;
      didx_q      <= '0;
      tag_last_q  <= 1'b0;
      tag_final_q <= 1'b0;
    end else if (load_i) begin
      drain_q     <= 1'b1;
      didx_q      <= TOP;
      fcnt_q      <= '0;
      tag_last_q  <= rec_last_i;
      tag_final_q <= rec_final_i;
    end else if (push_i) begin
      if (fcnt_q == TOP || rec_last_i) begin
        drain_q     <= 1'b1;
        didx_q      <= TOP;
        fcnt_q      <= '0;
        tag_last_q  <= rec_last_i;
        tag_final_q <= rec_final_i;
      end else begin
        fcnt_q <= fcnt_q + 1'b1;
      end
    end else if (drain_q && out_ready_i) begin
      if (didx_q == '0) drain_q <= 1'b0;
      else              didx_q  <= didx_q - 1'b1;
    end
  end

  // lanes return to zero after each drain so a short group is padded
  for (genvar g = 0; g < NB; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              lane_q[g] <= '0;
      else if (load_i)                          lane_q[g] <= load_data_i[8*g +: 8];
      else if (push_i && fcnt_q == IW'(g))      lane_q[g] <= push_data_i;
      else if (drain_done)                      lane_q[g] <= '0;
    end
  end

  assign idle_o      = !drain_q && (fcnt_q == '0);
  assign can_push_o  = !drain_q;
  assign out_valid_o = drain_q;
  assign out_data_o  = lane_q[didx_q];
  assign out_last_o  = drain_q && tag_last_q && (didx_q == '0);
  assign out_final_o = drain_q && tag_final_q;

  p_load_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (!drain_q && fcnt_q == '0));
  p_push_fill_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !drain_q);
  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)
      && $stable(out_last_o) && $stable(out_final_o)));
endmodule

// File: rtl/fwp_ctrl.sv
module fwp_ctrl
  import fwp_pkg::*;
#(
  parameter int         SIZE_W    = 32,
  parameter logic [7:0] INFO_VER  = 8'd1,
  parameter logic [7:0] TARGET_ID = 8'd10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [SIZE_W-1:0] image_bytes_i,
  input  logic              boot_fail_i,
  input  logic              in_valid_i,
  input  logic [7:0]        in_data_i,
  output logic              in_ready_o,
  input  logic [31:0]       hdr_i,
  input  logic              hdr_full_i,
  output logic              hdr_wr_o,
  output logic              hdr_clr_o,
  input  logic              buf_idle_i,
  input  logic              buf_can_push_i,
  output logic              buf_load_o,
  output logic              buf_push_o,
  output logic              rec_last_o,
  output logic              rec_final_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [2:0]        err_o
);
  localparam int OFS_W = SIZE_W + 1;

  state_e            state_q;
  logic [SIZE_W-1:0] size_q;
  logic [OFS_W-1:0]  offset_q;
  logic [LEN_W-1:0]  len_q, cnt_q;
  logic              final_q, first_q, fail_q;
  logic [7:0]        ver_q, tgt_q;
  err_e              err_q;

  logic [7:0]       hdr_cmd;
  logic [LEN_W-1:0] hdr_len;
  logic [OFS_W-1:0] rec_end;
  logic             fail_now, body_last, in_fire;

  assign hdr_cmd   = hdr_i[7:0];
  assign hdr_len   = hdr_i[8 +: LEN_W];
  assign rec_end   = offset_q + OFS_W'(hdr_len) + OFS_W'(HDR_BYTES);
  assign fail_now  = fail_q || boot_fail_i;
  assign body_last = (cnt_q == len_q - LEN_W'(1));
  assign in_fire   = in_valid_i && in_ready_o;

  always_comb begin
    case (state_q)
      S_HDR:   in_ready_o = !hdr_full_i;
      S_INFO:  in_ready_o = 1'b1;
      S_BODY:  in_ready_o = buf_can_push_i;
      default: in_ready_o = 1'b0;
    endcase
  end

  assign hdr_wr_o    = (state_q == S_HDR) && in_fire;
  assign hdr_clr_o   = (state_q == S_IDLE) || (state_q == S_INFO_CHK)
                     || ((state_q == S_LOAD) && buf_idle_i);
  assign buf_load_o  = (state_q == S_LOAD) && buf_idle_i && !fail_now;
  assign buf_push_o  = (state_q == S_BODY) && in_fire;
  assign rec_last_o  = (state_q == S_LOAD) ? (len_q == '0) : body_last;
  assign rec_final_o = final_q;
  assign busy_o      = (state_q != S_IDLE);
  assign done_o      = (state_q == S_END);
  assign err_o       = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      size_q   <= '0;
      offset_q <= '0;
      len_q    <= '0;
      cnt_q    <= '0;
      final_q  <= 1'b0;
      first_q  <= 1'b0;
      fail_q   <= 1'b0;
      ver_q    <= '0;
      tgt_q    <= '0;
      err_q    <= ERR_NONE;
    end else begin
      if (state_q != S_IDLE && boot_fail_i) fail_q <= 1'b1;
      case (state_q)
        S_IDLE: if (start_i) begin
          size_q   <= image_bytes_i;
          offset_q <= '0;
          first_q  <= 1'b1;
          fail_q   <= 1'b0;
          final_q  <= 1'b0;
          err_q    <= ERR_NONE;
          state_q  <= S_HDR;
        end
        S_HDR: if (hdr_full_i) state_q <= S_DECIDE;
        S_DECIDE: begin
          offset_q <= rec_end;
          final_q  <= (rec_end >= {1'b0, size_q});
          len_q    <= hdr_len;
          cnt_q    <= '0;
          if (fail_now) begin
            err_q <= ERR_ABORT;  state_q <= S_FLUSH;
          end else if (first_q) begin
            if (hdr_cmd != CMD_INFO) begin
              err_q <= ERR_NOT_INFO;  state_q <= S_FLUSH;
            end else if (hdr_len < LEN_W'(INFO_MIN_LEN)) begin
              err_q <= ERR_SHORT_INFO;  state_q <= S_FLUSH;
            end else begin
              state_q <= S_INFO;
            end
          end else begin
            state_q <= S_LOAD;
          end
        end
        S_INFO: if (in_fire) begin
          if (cnt_q == LEN_W'(0)) ver_q <= in_data_i;
          if (cnt_q == LEN_W'(3)) tgt_q <= in_data_i;
          cnt_q <= cnt_q + 1'b1;
          if (body_last) state_q <= S_INFO_CHK;
        end
        S_INFO_CHK: begin
          if (ver_q != INFO_VER) begin
            err_q <= ERR_VERSION;  state_q <= S_FLUSH;
          end else if (tgt_q != TARGET_ID) begin
            err_q <= ERR_TARGET;  state_q <= S_FLUSH;
          end else begin
            first_q <= 1'b0;
            state_q <= final_q ? S_FLUSH : S_HDR;
          end
        end
        S_LOAD: begin
          if (fail_now) begin
            err_q <= ERR_ABORT;  state_q <= S_FLUSH;
          end else if (buf_idle_i) begin
            if (len_q == '0) state_q <= final_q ? S_FLUSH : S_HDR;
            else             state_q <= S_BODY;
          end
        end
        S_BODY: if (in_fire) begin
          cnt_q <= cnt_q + 1'b1;
          if (body_last) state_q <= final_q ? S_FLUSH : S_HDR;
        end
        S_FLUSH: if (buf_idle_i) state_q <= S_END;
        S_END:   state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  p_abort_no_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q == ERR_ABORT) |-> !buf_load_o);
  p_info_not_sent_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_q |-> !buf_load_o && !buf_push_o);
  p_size_locked_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != S_IDLE && state_q != S_END) |=> $stable(size_q));
endmodule

// File: rtl/fw_record_parser.sv
module fw_record_parser
  import fwp_pkg::*;
#(
  parameter int         SIZE_W    = 32,
  parameter logic [7:0] INFO_VER  = 8'd1,
  parameter logic [7:0] TARGET_ID = 8'd10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [SIZE_W-1:0] image_bytes_i,
  input  logic              boot_fail_i,
  input  logic              in_valid_i,
  input  logic [7:0]        in_data_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic [7:0]        out_data_o,
  output logic              out_last_o,
  output logic              out_final_o,
  input  logic              out_ready_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [2:0]        err_o
);
  logic [8*HDR_BYTES-1:0] hdr;
  logic hdr_full, hdr_wr, hdr_clr;
  logic buf_idle, buf_can_push, buf_load, buf_push, rec_last, rec_final;

  fwp_hdr_cap #(.NB(HDR_BYTES)) u_hdr (
    .clk_i, .rst_ni,
    .clr_i  (hdr_clr),
    .wr_i   (hdr_wr),
    .data_i (in_data_i),
    .hdr_o  (hdr),
    .full_o (hdr_full)
  );

  fwp_ctrl #(.SIZE_W(SIZE_W), .INFO_VER(INFO_VER), .TARGET_ID(TARGET_ID)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .image_bytes_i, .boot_fail_i,
    .in_valid_i, .in_data_i, .in_ready_o,
    .hdr_i          (hdr[31:0]),
    .hdr_full_i     (hdr_full),
    .hdr_wr_o       (hdr_wr),
    .hdr_clr_o      (hdr_clr),
    .buf_idle_i     (buf_idle),
    .buf_can_push_i (buf_can_push),
    .buf_load_o     (buf_load),
    .buf_push_o     (buf_push),
    .rec_last_o     (rec_last),
    .rec_final_o    (rec_final),
    .busy_o, .done_o, .err_o
  );

  fwp_grp_swap #(.NB(GRP_BYTES)) u_swap (
    .clk_i, .rst_ni,
    .load_i      (buf_load),
    .load_data_i (hdr),
    .push_i      (buf_push),
    .push_data_i (in_data_i),
    .rec_last_i  (rec_last),
    .rec_final_i (rec_final),
    .idle_o      (buf_idle),
    .can_push_o  (buf_can_push),
    .out_valid_o, .out_data_o, .out_last_o, .out_final_o, .out_ready_i
  );

  p_done_drained_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !out_valid_o);
  p_done_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);
endmodule

// File: tb/sim_fw_record_parser.sv
module sim_fw_record_parser;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, boot_fail = 1'b0, in_valid = 1'b0, out_ready = 1'b0;
  logic [31:0] image_bytes = '0;
  logic [7:0] in_data = '0;
  logic in_ready, out_valid, out_last, out_final, busy, done;
  logic [7:0] out_data;
  logic [2:0] err;

  int checks = 0, failures = 0;
  logic [7:0] img_q[$];
  logic [9:0] exp_q[$];

  always #2 clk = ~clk;

  fw_record_parser u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .image_bytes_i(image_bytes),
    .boot_fail_i(boot_fail), .in_valid_i(in_valid), .in_data_i(in_data),
    .in_ready_o(in_ready), .out_valid_o(out_valid), .out_data_o(out_data),
    .out_last_o(out_last), .out_final_o(out_final), .out_ready_i(out_ready),
    .busy_o(busy), .done_o(done), .err_o(err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic add_rec(input logic [7:0] cmd, input int len, input logic [31:0] addr,
                         input bit emit, input bit fin);
    logic [7:0] b[$];
    int n, ng;
    b.push_back(cmd);
    b.push_back(len[7:0]); b.push_back(len[15:8]); b.push_back(len[23:16]);
    for (int k = 0; k < 4; k++) b.push_back(addr[8*k +: 8]);
    for (int k = 0; k < len; k++) b.push_back(8'(k * 7 + int'(cmd) * 13 + 5));
    foreach (b[k]) img_q.push_back(b[k]);
    if (emit) begin
      n  = len + 8;
      ng = (n + 7) / 8;
      for (int g = 0; g < ng; g++)
        for (int p = 7; p >= 0; p--) begin
          int i = g * 8 + p;
          logic [7:0] v = (i < n) ? b[i] : 8'h00;
          logic lst = (g == ng - 1) && (p == 0);
          exp_q.push_back({fin, lst, v});
        end
    end
  endtask

  task automatic add_info(input logic [7:0] cmd, input logic [7:0] ver,
                          input logic [7:0] tgt, input int len);
    img_q.push_back(cmd);
    img_q.push_back(len[7:0]); img_q.push_back(len[15:8]); img_q.push_back(len[23:16]);
    for (int k = 0; k < 4; k++) img_q.push_back(8'h00);
    for (int k = 0; k < len; k++)
      img_q.push_back(k == 0 ? ver : k == 1 ? 8'd2 : k == 2 ? 8'd0 : k == 3 ? tgt : 8'(k + 40));
  endtask

  // fail_mode: 0 none, 1 raised right after start, 2 raised at first output byte
  task automatic run(input int size, input int fail_mode, input bit probe,
                     input int exp_err, input int exp_cons, input string req);
    int idx = 0, oi = 0, cyc = 0;
    bit seen_done = 0, stalled = 0;
    logic [7:0] hold_d = '0;
    @(negedge clk);
    image_bytes = size; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    boot_fail = (fail_mode == 1);
    while (!seen_done && cyc < 4000) begin
      cyc++;
      in_valid  = (idx < img_q.size()) && (cyc % 5 != 2);
      in_data   = in_valid ? img_q[idx] : 8'h00;
      out_ready = (cyc % 3 != 1);
      if (probe && cyc == 15) begin start = 1'b1; image_bytes = 8; end
      else start = 1'b0;
      #1;
      if (cyc == 3) chk(busy, "R12", "busy during job", busy, 1);
      if (stalled) chk(out_valid && out_data == hold_d, "R11", "hold under stall",
                       {out_valid, out_data}, {1'b1, hold_d});
      stalled = out_valid && !out_ready;
      hold_d  = out_data;
      if (in_valid && in_ready) idx++;
      if (out_valid && out_ready) begin
        if (oi < exp_q.size())
          chk({out_final, out_last, out_data} == exp_q[oi], req, $sformatf("out byte %0d", oi),
              {out_final, out_last, out_data}, exp_q[oi]);
        else
          chk(0, req, "extra output byte", out_data, 0);
        oi++;
        if (fail_mode == 2 && oi == 1) boot_fail = 1'b1;
      end
      if (done) begin
        seen_done = 1;
        chk(!out_valid, "R12", "drained at done", out_valid, 0);
      end
      @(negedge clk);
    end
    start = 1'b0; in_valid = 1'b0;
    chk(seen_done, req, "job finished", seen_done, 1);
    chk(err == 3'(exp_err), req, "result code", err, exp_err);
    chk(oi == exp_q.size(), req, "output count", oi, exp_q.size());
    if (exp_cons >= 0) chk(idx == exp_cons, req, "bytes consumed", idx, exp_cons);
    #1;
    chk(!busy && !done, "R12", "idle after done", {busy, done}, 0);
    boot_fail = 1'b0;
    img_q.delete();
    exp_q.delete();
  endtask

  task automatic t_reset;
    chk(!busy && !done && !out_valid && !in_ready && err == 0, "R1", "reset state",
        {busy, done, out_valid, in_ready, err}, 0);
  endtask

  // R2 R5 R6 R8 R9: aligned records, last one final
  task automatic t_basic;
    add_info(8'hFF, 8'd1, 8'd10, 4);
    add_rec(8'h02, 8, 32'h1234_5678, 1, 0);
    add_rec(8'h03, 16, 32'hA0B0_C0D0, 1, 1);
    run(12 + 16 + 24, 0, 0, 0, 52, "R6");
  endtask

  // R7: unaligned records padded, zero-length record
  task automatic t_pad;
    add_info(8'hFF, 8'd1, 8'd10, 4);
    add_rec(8'h01, 3, 32'h0000_0100, 1, 0);
    add_rec(8'h04, 0, 32'h0000_0200, 1, 0);
    add_rec(8'h03, 13, 32'h0000_0300, 1, 1);
    run(12 + 11 + 8 + 21, 0, 0, 0, 52, "R7");
  endtask

  // R9: size ends inside second record, third untouched
  task automatic t_short_size;
    add_info(8'hFF, 8'd1, 8'd10, 6);
    add_rec(8'h02, 8, 32'h0000_1000, 1, 0);
    add_rec(8'h03, 5, 32'h0000_2000, 1, 1);
    add_rec(8'h03, 8, 32'h0000_3000, 0, 0);
    run(40, 0, 0, 0, 43, "R9");
  endtask

  // R9: info record alone reaches the size
  task automatic t_info_only;
    add_info(8'hFF, 8'd1, 8'd10, 4);
    add_rec(8'h02, 8, 32'h0, 0, 0);
    run(12, 0, 0, 0, 12, "R9");
  endtask

  task automatic t_not_info;  // R3
    add_info(8'h02, 8'd1, 8'd10, 4);
    add_rec(8'h02, 8, 32'h0, 0, 0);
    run(28, 0, 0, 1, 8, "R3");
  endtask

  task automatic t_bad_info;  // R4
    add_info(8'hFF, 8'd2, 8'd10, 4);
    add_rec(8'h02, 8, 32'h0, 0, 0);
    run(28, 0, 0, 2, 12, "R4");
    add_info(8'hFF, 8'd1, 8'd11, 4);
    add_rec(8'h02, 8, 32'h0, 0, 0);
    run(28, 0, 0, 3, 12, "R4");
    add_info(8'hFF, 8'd1, 8'd10, 2);
    add_rec(8'h02, 8, 32'h0, 0, 0);
    run(26, 0, 0, 4, 8, "R4");
  endtask

  task automatic t_abort;  // R10
    add_info(8'hFF, 8'd1, 8'd10, 4);
    add_rec(8'h02, 8, 32'h0, 0, 1);
    run(28, 1, 0, 5, 8, "R10");
    add_info(8'hFF, 8'd1, 8'd10, 4);
    add_rec(8'h03, 16, 32'h5555_0000, 1, 0);
    add_rec(8'h03, 8, 32'h6666_0000, 0, 1);
    run(12 + 24 + 16, 2, 0, 5, -1, "R10");
  endtask

  task automatic t_restart_ignored;  // R13
    add_info(8'hFF, 8'd1, 8'd10, 4);
    add_rec(8'h02, 8, 32'h0BAD_F00D, 1, 0);
    add_rec(8'h03, 16, 32'h0000_0040, 1, 1);
    run(52, 0, 1, 0, 52, "R13");
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_pad();
    t_short_size();
    t_info_only();
    t_not_info();
    t_bad_info();
    t_abort();
    t_restart_ignored();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule